// File: doc/BRIEF.md
# USB Controller Interrupt Aggregator

This block collects five USB controller event sources into one level interrupt line for the processor. Each source has a sticky status bit and an enable bit. Hardware pulses on `evt_i` set the status bits. Software reads the status and enable registers through a small register port. It acknowledges a source by writing a one to its status bit.

Three sources are immediate: system error, port change and frame list rollover. Each one drives the interrupt as soon as its status and enable bits are both set. Frame list rollover counts only while the controller runs as a host. The other two sources are deferred: transfer error and transfer complete. Each one is held back until an interrupt-threshold tick finds its status bit already latched.

The block carries no data stream, so it has no valid/ready handshake. The event, tick, mode and register pins are plain, cycle-level controls. A write takes effect on the clock edge that samples it. A read is combinational from the selected register.

Top module: `usb_irq_aggr`

## Requirements
- R1: Bit positions are fixed in both registers. Bit 4 is system error, bit 3 is frame list rollover, bit 2 is port change, bit 1 is transfer error and bit 0 is transfer complete. A one on `evt_i[b]` sets status bit b, and the new value reads back on `rd_data_o` with `rd_sel_i`=0 from the next cycle.
- R2: A write with `wr_sel_i`=0 clears each status bit whose `wr_data_i` bit is 1. Status bits whose data bit is 0 keep their value.
- R3: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R4: A write with `wr_sel_i`=1 loads the enable register, which reads back with `rd_sel_i`=1. A source whose enable bit is 0 never drives `irq_o`.
- R5: An enabled system error (bit 4) or port change (bit 2) raises `irq_o` one cycle after its status bit becomes visible. No tick is needed.
- R6: Frame list rollover (bit 3) contributes to `irq_o` only while `host_mode_i`=1. With `host_mode_i`=0 its status bit can still be set, but it never asserts `irq_o`.
- R7: Transfer error and transfer complete (bits 1 and 0) contribute only after `tick_i` is sampled while their status bit is already 1. A tick in the same cycle as the setting event does not release the bit.
- R8: A released deferred bit keeps contributing until its status bit is cleared. If the bit is set again after that clear, it needs a fresh tick.
- R9: `irq_o` is registered. It falls one cycle after the last qualifying status bit clears or loses its enable.
- R10: After reset, the status register, the enable register and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 5 | Event pulses that set status bits |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 status (write-one-to-clear), 1 enable |
| wr_data_i | input | 5 | Write data |
| rd_sel_i | input | 1 | Read select: 0 status, 1 enable |
| rd_data_o | output | 5 | Selected register value |
| tick_i | input | 1 | Interrupt-threshold tick |
| host_mode_i | input | 1 | 1 when the controller runs as a host |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest state to reach is a deferred source that is latched and enabled but not yet released, especially when a tick lands in the same cycle as its event. The state where it is released and then set again after a clear is just as hard. Directed sequences place the tick in the event cycle, then several idle cycles later. They then clear the bit and set it again without a tick. A long random phase with sparse ticks, events, clears and mode changes follows. A behavioural model checks it on every clock.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int unsigned NSRC = 5;

  typedef enum int unsigned {
    SRC_XFER_DONE = 0,
    SRC_XFER_ERR  = 1,
    SRC_PORT_CHG  = 2,
    SRC_ROLLOVER  = 3,
    SRC_SYS_ERR   = 4
  } src_e;

  typedef logic [NSRC-1:0] srcvec_t;

  localparam srcvec_t DEFER_MASK_DEF     = srcvec_t'((1 << SRC_XFER_DONE) | (1 << SRC_XFER_ERR));
  localparam srcvec_t HOST_ONLY_MASK_DEF = srcvec_t'(1 << SRC_ROLLOVER);
endpackage

// File: rtl/usb_irq_status.sv
module usb_irq_status #(
  parameter int unsigned N = usb_irq_pkg::NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_q_o,
  output logic [N-1:0] stat_d_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic bit_q;

    // set has priority over a same-cycle clear
    assign stat_d_o[b] = set_i[b] | (bit_q & ~clr_i[b]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= stat_d_o[b];
    end

    assign stat_q_o[b] = bit_q;

    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[b] |=> stat_q_o[b]);
    assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[b] && !set_i[b]) |=> !stat_q_o[b]);
  end
endmodule

// File: rtl/usb_irq_defer.sv
module usb_irq_defer #(
  parameter int unsigned N = usb_irq_pkg::NSRC,
  parameter logic [N-1:0] DEFER = usb_irq_pkg::DEFER_MASK_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic [N-1:0] stat_q_i,
  input  logic [N-1:0] stat_d_i,
  output logic [N-1:0] rel_o
);
  logic [N-1:0] rel_q, rel_d;

  always_comb begin
    rel_d = rel_q;
    if (tick_i) rel_d = rel_d | stat_q_i;
    rel_d = rel_d & stat_d_i & DEFER;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_q <= '0;
    else        rel_q <= rel_d;
  end

  assign rel_o = rel_q;

  for (genvar b = 0; b < N; b++) begin : g_chk
    if (DEFER[b]) begin : g_def
      assert_release_needs_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rel_q[b]) |-> $past(tick_i));
      assert_release_tracks_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rel_q[b] |-> stat_q_i[b]);
    end
  end
endmodule

// File: rtl/usb_irq_combine.sv
module usb_irq_combine #(
  parameter int unsigned N = usb_irq_pkg::NSRC,
  parameter logic [N-1:0] DEFER     = usb_irq_pkg::DEFER_MASK_DEF,
  parameter logic [N-1:0] HOST_ONLY = usb_irq_pkg::HOST_ONLY_MASK_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] stat_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] rel_i,
  input  logic         host_i,
  output logic         irq_o
);
  localparam logic [N-1:0] ALWAYS = ~(DEFER | HOST_ONLY);

  logic [N-1:0] gate, qual;
  logic         irq_q;

  assign gate = (rel_i & DEFER)
              | (HOST_ONLY & ~DEFER & {N{host_i}})
              | ALWAYS;
  assign qual = stat_i & en_i & gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |qual;
  end

  assign irq_o = irq_q;

  assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |=> !irq_o);
  assert_idle_drops_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_i == '0) |=> !irq_o);
endmodule

// File: rtl/usb_irq_aggr.sv
module usb_irq_aggr
  import usb_irq_pkg::*;
#(
  parameter int unsigned N = NSRC,
  parameter logic [N-1:0] DEFER     = DEFER_MASK_DEF,
  parameter logic [N-1:0] HOST_ONLY = HOST_ONLY_MASK_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         wr_en_i,
  input  logic         wr_sel_i,
  input  logic [N-1:0] wr_data_i,
  input  logic         rd_sel_i,
  output logic [N-1:0] rd_data_o,
  input  logic         tick_i,
  input  logic         host_mode_i,
  output logic         irq_o
);
  logic [N-1:0] en_q, clr, stat_q, stat_d, rel;

  assign clr = (wr_en_i && !wr_sel_i) ? wr_data_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  en_q <= '0;
    else if (wr_en_i && wr_sel_i) en_q <= wr_data_i;
  end

  usb_irq_status #(.N(N)) u_status (
    .clk(clk), .rst_n(rst_n), .set_i(evt_i), .clr_i(clr),
    .stat_q_o(stat_q), .stat_d_o(stat_d)
  );

  usb_irq_defer #(.N(N), .DEFER(DEFER)) u_defer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .stat_q_i(stat_q), .stat_d_i(stat_d), .rel_o(rel)
  );

  usb_irq_combine #(.N(N), .DEFER(DEFER), .HOST_ONLY(HOST_ONLY)) u_combine (
    .clk(clk), .rst_n(rst_n), .stat_i(stat_q), .en_i(en_q),
    .rel_i(rel), .host_i(host_mode_i), .irq_o(irq_o)
  );

  assign rd_data_o = rd_sel_i ? en_q : stat_q;

  assert_enable_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i) |=> (en_q == $past(wr_data_i)));
endmodule

// File: tb/usb_irq_aggr_tb_top.sv
module usb_irq_aggr_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] evt_i = '0;
  logic       wr_en_i = 1'b0;
  logic       wr_sel_i = 1'b0;
  logic [4:0] wr_data_i = '0;
  logic       rd_sel_i = 1'b0;
  logic [4:0] rd_data_o;
  logic       tick_i = 1'b0;
  logic       host_mode_i = 1'b0;
  logic       irq_o;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  usb_irq_aggr dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_o), .tick_i(tick_i), .host_mode_i(host_mode_i),
    .irq_o(irq_o)
  );

  // behavioural reference model
  int m_st = 0, m_en = 0, m_rel = 0, m_irq = 0;

  always @(posedge clk) begin
    int clr_v, st_n, imm, q;
    if (!rst_n) begin
      m_st = 0; m_en = 0; m_rel = 0; m_irq = 0;
    end else begin
      imm   = 'h14 | (host_mode_i ? 'h08 : 0);
      q     = m_st & m_en & (imm | m_rel);
      m_irq = (q != 0) ? 1 : 0;
      clr_v = (wr_en_i && !wr_sel_i) ? int'(wr_data_i) : 0;
      st_n  = (m_st & ~clr_v & 'h1f) | int'(evt_i);
      m_rel = (m_rel | (tick_i ? m_st : 0)) & st_n & 'h03;
      m_st  = st_n;
      if (wr_en_i && wr_sel_i) m_en = int'(wr_data_i);
    end
    #3;
    if (rst_n) begin
      compared++;
      if (int'(rd_data_o) != (rd_sel_i ? m_en : m_st)) begin
        mismatched++;
        $display("FAIL R1 register read: got %0h expected %0h", rd_data_o, rd_sel_i ? m_en : m_st);
      end
      compared++;
      if (int'(irq_o) != m_irq) begin
        mismatched++;
        $display("FAIL R9 irq vs model: got %0d expected %0d", irq_o, m_irq);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit sel, logic [4:0] d);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    step();
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    rd_sel_i = 1'b0; #1 chk("R10 status reset", int'(rd_data_o), 0);
    rd_sel_i = 1'b1; #1 chk("R10 enable reset", int'(rd_data_o), 0);
    chk("R10 irq reset", int'(irq_o), 0);

    wr(1'b1, 5'h1f);
    chk("R4 enable readback", int'(rd_data_o), 'h1f);
    rd_sel_i = 1'b0;

    // immediate port change
    evt_i = 5'h04; step(); evt_i = '0;
    chk("R1 status bit2 set", int'(rd_data_o), 'h04);
    step();
    chk("R5 port change irq", int'(irq_o), 1);
    wr(1'b0, 5'h04);
    chk("R2 w1c clears", int'(rd_data_o), 0);
    chk("R9 irq still high one cycle", int'(irq_o), 1);
    step();
    chk("R9 irq falls", int'(irq_o), 0);

    // rollover in device then host mode
    host_mode_i = 1'b0;
    evt_i = 5'h08; step(); evt_i = '0;
    step(2);
    chk("R6 rollover device quiet", int'(irq_o), 0);
    chk("R6 rollover status latched", int'(rd_data_o), 'h08);
    host_mode_i = 1'b1; step();
    chk("R6 rollover host irq", int'(irq_o), 1);
    wr(1'b0, 5'h08); step();
    chk("R9 rollover cleared", int'(irq_o), 0);

    // deferred transfer complete: tick in event cycle does not release
    evt_i = 5'h01; tick_i = 1'b1; step(); evt_i = '0; tick_i = 1'b0;
    step(2);
    chk("R7 tick with event no release", int'(irq_o), 0);
    tick_i = 1'b1; step(); tick_i = 1'b0;
    chk("R7 irq not yet", int'(irq_o), 0);
    step();
    chk("R7 released after tick", int'(irq_o), 1);
    step(3);
    chk("R8 stays released", int'(irq_o), 1);
    wr(1'b0, 5'h01); step();
    chk("R9 deferred cleared", int'(irq_o), 0);
    evt_i = 5'h01; step(); evt_i = '0; step(3);
    chk("R8 reset needs new tick", int'(irq_o), 0);
    wr(1'b0, 5'h01);

    // set wins over clear
    evt_i = 5'h02; wr_en_i = 1'b1; wr_sel_i = 1'b0; wr_data_i = 5'h02;
    step(); evt_i = '0; wr_en_i = 1'b0; wr_data_i = '0;
    chk("R3 set wins", int'(rd_data_o), 'h02);
    wr(1'b0, 5'h02);
    chk("R2 cleared after", int'(rd_data_o), 0);
    wr(1'b0, 5'h1f); // zero-data bits untouched check below
    evt_i = 5'h10; step(); evt_i = '0;
    wr(1'b0, 5'h01);
    chk("R2 unselected bit kept", int'(rd_data_o), 'h10);
    wr(1'b0, 5'h10); step();

    // all disabled
    wr(1'b1, 5'h00);
    evt_i = 5'h1f; tick_i = 1'b1; step(); evt_i = '0; step(); tick_i = 1'b0;
    step(2);
    chk("R4 disabled quiet", int'(irq_o), 0);
    wr(1'b1, 5'h1f); step();
    chk("R4 enable exposes pending", int'(irq_o), 1);
    wr(1'b0, 5'h1f); step();

    // random phase, model compared each clock
    for (int i = 0; i < 4000; i++) begin
      evt_i       = (($urandom % 6) == 0) ? 5'($urandom) : 5'h00;
      tick_i      = (($urandom % 9) == 0);
      host_mode_i = (($urandom % 50) == 0) ? ~host_mode_i : host_mode_i;
      rd_sel_i    = 1'($urandom);
      wr_en_i     = (($urandom % 5) == 0);
      wr_sel_i    = (($urandom % 4) == 0);
      wr_data_i   = 5'($urandom);
      step();
    end
    evt_i = '0; tick_i = 1'b0; wr_en_i = 1'b0;
    step(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule